// File: doc/BRIEF.md
# CPU Idle Mode Controller

This block puts a small processor core to sleep and wakes it up again. Software writes a one into the idle bit of an 8-bit power-control register. The block then stops the clock that drives the CPU core. The clock that feeds the interrupt controller, the timers and the serial port is not touched. While the core is halted, any interrupt that is both pending and enabled starts the core clock again. In that same cycle the hardware clears the idle bit, so the core can service the interrupt and then carry on from the instruction after the register write.

The core clock enable comes from a flop on the falling edge of the free-running clock. The gated clock, the free clock ANDed with that enable, can therefore only start or stop at a rising edge and never produces a runt pulse. A write that sets the idle bit still gets the core clock edge that completes it. Gating starts with the edge after that write. Writes attempted while the core clock is stopped are dropped, because no core can be issuing them. The power-down mode and the CPU core itself are outside this block.

Top module: `cpu_idle_ctrl`

## Requirements
- R1: During and right after reset, the power-control register reads 0x00, `core_clk_en` is 1 and `wake_ack` is 0.
- R2: A write with `sfr_addr` = 0x87 while the core clock runs loads all 8 bits of `sfr_wdata` at the next rising edge. `sfr_rdata` shows the register whenever `sfr_addr` = 0x87 and shows 0x00 for any other address. Writes to other addresses leave the register unchanged.
- R3: While bit 0 (idle) is 1 and no enabled interrupt is pending, `core_clk_en` is 0 from the falling edge of that cycle. The core clock then has no rising edge until a wake-up.
- R4: An interrupt wakes the core when `irq_gie` is 1 and at least one bit of `irq_pend & irq_en` is 1. `core_clk_en` returns to 1 at the falling edge of the cycle in which the interrupt appears. Bit 0 clears at the next rising edge.
- R5: Interrupts that are masked do not end idle: an interrupt is masked when its `irq_en` bit is 0, or when `irq_gie` is 0.
- R6: If an enabled interrupt is pending in the cycle after idle is written, the core clock never stops, and bit 0 is cleared at the following edge.
- R7: `wake_ack` is 1 for exactly one cycle, following each rising edge at which an interrupt clears bit 0.
- R8: A write issued while `core_clk_en` is 0 has no effect on the register.
- R9: Bits 7 to 1 of the register keep their written value across idle entry and wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock, also used by the peripherals |
| rst_n | input | 1 | Asynchronous reset, active low |
| sfr_wr | input | 1 | Register write strobe from the core |
| sfr_addr | input | 8 | Register address for both read and write |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, combinational from `sfr_addr` |
| irq_pend | input | 6 | Pending interrupt request per source |
| irq_en | input | 6 | Enable per interrupt source |
| irq_gie | input | 1 | Global interrupt enable |
| core_clk | output | 1 | Gated clock for the CPU core |
| core_clk_en | output | 1 | Registered enable of the core clock gate |
| wake_ack | output | 1 | One-cycle pulse after an interrupt clears idle |

## Verification
The hardest case to reach is a collision at the edge that follows an idle write. Here the idle bit has just been set while an enabled interrupt is already pending. The gate must then stay open and the bit must fall again one edge later. The stimulus creates this by setting the interrupt inputs in the same cycle as the idle write. A second hard case is a write arriving while the core clock is stopped, which a real core could never issue. The bench drives the write strobe directly during the halted cycles. A register readback after wake-up then shows that the write was dropped.

// File: rtl/cic_pkg.sv
package cic_pkg;

  typedef enum logic [1:0] {
    CIC_RUN   = 2'd0,
    CIC_SLEEP = 2'd1,
    CIC_WAKE  = 2'd2
  } cic_state_e;

  // The core may run unless idle is requested and nothing wakes it.
  function automatic logic f_run_ok(input logic idle, input logic wake);
    return !(idle && !wake);
  endfunction

  // Next value of the idle bit: an accepted write wins, then a wake clears.
  function automatic logic f_idle_next(input logic idle, input logic hit,
                                       input logic wdata_bit, input logic wake);
    if (hit) return wdata_bit;
    return idle && !wake;
  endfunction

endpackage

// File: rtl/cic_wake_detect.sv
module cic_wake_detect #(
  parameter int unsigned N_IRQ = 6
) (
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             irq_gie,
  output logic             wake
);

  logic [N_IRQ-1:0] src_hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign src_hit[i] = irq_pend[i] & irq_en[i];
  end

  assign wake = irq_gie & (|src_hit);

endmodule

// File: rtl/cic_pcon_reg.sv
module cic_pcon_reg #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PCON_ADDR = 'h87,
  parameter int unsigned IDLE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              accept,
  input  logic              wake,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] pcon_q,
  output logic              idle_bit,
  output logic              idle_nxt,
  output logic              wr_hit,
  output logic              wake_clear
);
  import cic_pkg::*;

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(PCON_ADDR);

  logic addr_match;

  assign addr_match = (addr == HIT_ADDR);
  assign wr_hit     = wr_en && addr_match && accept;
  assign idle_bit   = pcon_q[IDLE_BIT];
  assign wake_clear = idle_bit && wake && !wr_hit;
  assign idle_nxt   = f_idle_next(idle_bit, wr_hit, wdata[IDLE_BIT], wake);
  assign rdata      = addr_match ? pcon_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcon_q <= '0;
    end else if (wr_hit) begin
      pcon_q <= wdata;
    end else if (wake_clear) begin
      pcon_q[IDLE_BIT] <= 1'b0;
    end
  end

endmodule

// File: rtl/cic_idle_fsm.sv
module cic_idle_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_bit,
  input  logic idle_nxt,
  input  logic wake,
  input  logic wake_clear,
  output logic run_req,
  output logic wake_ack
);
  import cic_pkg::*;

  cic_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      CIC_RUN:   state_d = wake_clear ? CIC_WAKE : (idle_nxt ? CIC_SLEEP : CIC_RUN);
      CIC_SLEEP: state_d = wake_clear ? CIC_WAKE : (idle_nxt ? CIC_SLEEP : CIC_RUN);
      CIC_WAKE:  state_d = idle_nxt ? CIC_SLEEP : CIC_RUN;
      default:   state_d = CIC_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CIC_RUN;
    else        state_q <= state_d;
  end

  assign run_req  = f_run_ok(idle_bit, wake);
  assign wake_ack = (state_q == CIC_WAKE);

endmodule

// File: rtl/cic_clk_gate.sv
module cic_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_req,
  output logic en_q,
  output logic gclk
);

  // Enable captured while clk is low: gclk can only start or stop on a rising edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= run_req;
  end

  assign gclk = clk & en_q;

endmodule

// File: rtl/cpu_idle_ctrl.sv
module cpu_idle_ctrl #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned N_IRQ     = 6,
  parameter int unsigned PCON_ADDR = 'h87,
  parameter int unsigned IDLE_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sfr_wr,
  input  logic [ADDR_W-1:0] sfr_addr,
  input  logic [DATA_W-1:0] sfr_wdata,
  output logic [DATA_W-1:0] sfr_rdata,
  input  logic [N_IRQ-1:0]  irq_pend,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic              irq_gie,
  output logic              core_clk,
  output logic              core_clk_en,
  output logic              wake_ack
);

  logic              wake_w;
  logic              idle_bit_w;
  logic              idle_nxt_w;
  logic              wr_hit_w;
  logic              wake_clear_w;
  logic              run_req_w;
  logic [DATA_W-1:0] pcon_w;

  cic_wake_detect #(.N_IRQ(N_IRQ)) u_wake (
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .irq_gie  (irq_gie),
    .wake     (wake_w)
  );

  cic_pcon_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PCON_ADDR(PCON_ADDR), .IDLE_BIT(IDLE_BIT)
  ) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (sfr_wr),
    .addr       (sfr_addr),
    .wdata      (sfr_wdata),
    .accept     (core_clk_en),
    .wake       (wake_w),
    .rdata      (sfr_rdata),
    .pcon_q     (pcon_w),
    .idle_bit   (idle_bit_w),
    .idle_nxt   (idle_nxt_w),
    .wr_hit     (wr_hit_w),
    .wake_clear (wake_clear_w)
  );

  cic_idle_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_bit   (idle_bit_w),
    .idle_nxt   (idle_nxt_w),
    .wake       (wake_w),
    .wake_clear (wake_clear_w),
    .run_req    (run_req_w),
    .wake_ack   (wake_ack)
  );

  cic_clk_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_req (run_req_w),
    .en_q    (core_clk_en),
    .gclk    (core_clk)
  );

endmodule

// File: rtl/cic_checker.sv
module cic_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idle_bit,
  input logic              wake,
  input logic              wr_hit,
  input logic              core_clk_en,
  input logic              wake_ack,
  input logic [DATA_W-1:0] pcon_q
);

  AST_HALT_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !core_clk_en |-> idle_bit) else $error("halt without idle"); // R3

  AST_WAKE_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_bit && wake && !wr_hit) |=> !idle_bit) else $error("idle not cleared"); // R4

  AST_PENDING_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> core_clk_en) else $error("gated with wake pending"); // R6

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |=> !wake_ack) else $error("ack longer than one cycle"); // R7

  AST_ACK_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(idle_bit) && !$past(wr_hit)) |-> wake_ack) else $error("no ack"); // R7

  AST_HALT_FREEZES_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_clk_en && !wake) |=> $stable(pcon_q)) else $error("reg changed while halted"); // R8

endmodule

bind cpu_idle_ctrl cic_checker #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .idle_bit    (idle_bit_w),
  .wake        (wake_w),
  .wr_hit      (wr_hit_w),
  .core_clk_en (core_clk_en),
  .wake_ack    (wake_ack),
  .pcon_q      (pcon_w)
);

// File: tb/sim_cpu_idle_ctrl.sv
`timescale 1ns/1ps
module sim_cpu_idle_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic [5:0] irq_pend = '0;
  logic [5:0] irq_en = '0;
  logic       irq_gie = 1'b0;
  logic       core_clk, core_clk_en, wake_ack;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int core_edges = 0;
  int base_edges = 0;

  // reference model state
  logic [7:0] m_reg = 8'h00;
  logic       m_ack = 1'b0;
  int         m_edges = 0;

  always #10 clk = ~clk;  // 50 MHz

  cpu_idle_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_pend(irq_pend),
    .irq_en(irq_en), .irq_gie(irq_gie), .core_clk(core_clk),
    .core_clk_en(core_clk_en), .wake_ack(wake_ack)
  );

  always @(posedge core_clk) core_edges++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual cycle %0d expected < 5000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One cycle: drive after the rising edge, compare in the high-to-low half, update the model at the edge.
  task automatic step(input string req, input logic wr, input logic [7:0] addr,
                      input logic [7:0] wd, input logic [5:0] pend,
                      input logic [5:0] en, input logic gie);
    logic wake_m, run_m, acc_m;
    sfr_wr = wr; sfr_addr = addr; sfr_wdata = wd;
    irq_pend = pend; irq_en = en; irq_gie = gie;
    wake_m = gie && ((pend & en) != 6'd0);
    run_m  = !(m_reg[0] && !wake_m);
    #14;
    chk(req, "core_clk_en", core_clk_en, run_m);
    chk(req, "wake_ack", wake_ack, m_ack);
    chk(req, "sfr_rdata", sfr_rdata, (addr == 8'h87) ? m_reg : 8'h00);
    chk(req, "core edges", core_edges - base_edges, m_edges);
    @(posedge clk);
    acc_m = wr && (addr == 8'h87) && run_m;
    if (run_m) m_edges++;
    m_ack = m_reg[0] && wake_m && !acc_m;
    if (acc_m) m_reg = wd;
    else if (m_ack) m_reg[0] = 1'b0;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #15;
    chk("R1", "reset rdata", sfr_rdata, 0);
    sfr_addr = 8'h87; #1;
    chk("R1", "reset reg", sfr_rdata, 0);
    chk("R1", "reset en", core_clk_en, 1);
    chk("R1", "reset ack", wake_ack, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    base_edges = core_edges;
    // R1 R2: readback and address decode
    step("R1", 0, 8'h87, 8'h00, 6'h00, 6'h00, 1'b0);
    step("R2", 1, 8'h87, 8'h5A, 6'h00, 6'h00, 1'b0);
    step("R2", 1, 8'h80, 8'hFF, 6'h00, 6'h00, 1'b0);
    step("R2", 0, 8'h87, 8'h00, 6'h00, 6'h00, 1'b0);
    step("R2", 0, 8'h80, 8'h00, 6'h00, 6'h00, 1'b0);
    // R3: enter idle, keeping upper bits
    step("R3", 1, 8'h87, 8'h5B, 6'h00, 6'h00, 1'b0);
    step("R3", 0, 8'h87, 8'h00, 6'h00, 6'h00, 1'b0);
    step("R3", 0, 8'h87, 8'h00, 6'h00, 6'h00, 1'b0);
    // R5: masked interrupts do not wake
    step("R5", 0, 8'h87, 8'h00, 6'h3F, 6'h00, 1'b1);
    step("R5", 0, 8'h87, 8'h00, 6'h3F, 6'h3F, 1'b0);
    step("R5", 0, 8'h87, 8'h00, 6'h01, 6'h3E, 1'b1);
    // R8: write attempts while halted are dropped
    step("R8", 1, 8'h87, 8'h00, 6'h00, 6'h00, 1'b0);
    step("R8", 1, 8'h87, 8'hF0, 6'h00, 6'h00, 1'b0);
    // R4: enabled interrupt wakes the core
    step("R4", 0, 8'h87, 8'h00, 6'h20, 6'h20, 1'b1);
    step("R7", 0, 8'h87, 8'h00, 6'h00, 6'h00, 1'b0);
    step("R9", 0, 8'h87, 8'h00, 6'h00, 6'h00, 1'b0);
    // second idle period with a different source
    step("R3", 1, 8'h87, 8'h81, 6'h00, 6'h3F, 1'b1);
    step("R3", 0, 8'h87, 8'h00, 6'h00, 6'h3F, 1'b1);
    step("R4", 0, 8'h87, 8'h00, 6'h04, 6'h3F, 1'b1);
    step("R7", 0, 8'h87, 8'h00, 6'h04, 6'h3F, 1'b1);
    step("R9", 0, 8'h87, 8'h00, 6'h00, 6'h00, 1'b0);
    // R6: interrupt already pending around the idle write
    step("R6", 1, 8'h87, 8'h03, 6'h02, 6'h02, 1'b1);
    step("R6", 0, 8'h87, 8'h00, 6'h02, 6'h02, 1'b1);
    step("R6", 0, 8'h87, 8'h00, 6'h00, 6'h00, 1'b0);
    step("R6", 0, 8'h87, 8'h00, 6'h00, 6'h00, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule